// File: doc/BRIEF.md
# Priority Input Clock Selector

This block decides which of four reference clock inputs a downstream clock generator should follow, or whether it should stop following any input and hold its last frequency. It reads per-input loss-of-signal and frequency-offset alarms as synchronous level signals in its own clock domain. It combines them with a small set of configuration fields: a selection mode, a manual select value, four per-input priority ranks, per-input offset-alarm enables and a pairing bit. It produces an encoded active-input index, a hold flag and a one-cycle strobe that marks each change of either.

In manual mode the active input comes from a 2-bit select value. That value is taken from external pins or from a register field, as a source bit chooses. In the two automatic modes the block fails over by priority rank. The revertive mode always tracks the best qualified input. The non-revertive mode keeps the current input for as long as it stays qualified. With the pairing bit set, inputs 1/3 and 2/4 act as clock/frame-sync pairs, so only two candidates compete.

All outputs are registered. A change on any input appears on the outputs after the next rising clock edge.

Top module: `refsel_top`

## Requirements
- R1: Mode field mode_i encodes 2'b00 manual, 2'b01 automatic non-revertive and 2'b10 automatic revertive. The code 2'b11 behaves exactly as manual.
- R2: In manual mode the select value is sel_pin_i when sel_src_pin_i is 1 and sel_reg_i when it is 0. With pairing off, codes 0..3 make active_o 0..3 (inputs 1..4).
- R3: In either automatic mode, sel_reg_i, sel_pin_i and sel_src_pin_i have no effect on the outputs.
- R4: In manual mode, if the selected candidate is disqualified, hold_o is 1. Otherwise hold_o is 0.
- R5: In automatic mode the block selects the qualified candidate whose rank field (rank_i[2i+1:2i], 0 = highest) is smallest. A tie goes to the lower index. If no candidate is qualified, hold_o is 1 and active_o keeps its previous value.
- R6: After reset, on leaving hold, or on entering automatic mode from manual, the block selects the best qualified candidate in both automatic modes.
- R7: In revertive mode the block returns to the best-ranked candidate in the first cycle that candidate is qualified again.
- R8: In non-revertive mode the current candidate stays selected while it is qualified, even when a better-ranked one recovers.
- R9: A set los_i[i] always disqualifies input i. A set fos_i[i] disqualifies it only when fos_en_i[i] is 1.
- R10: With pair_i set, candidate 0 is inputs 1/3 and candidate 1 is inputs 2/4. A pair is disqualified if either member is. Only rank fields 0 and 1 are used. Manual codes 2 and 3 give hold_o = 1.
- R11: switch_o is 1 for exactly the one cycle in which active_o or hold_o takes a new value, and 0 otherwise. Reset leaves active_o = 0, hold_o = 0 and switch_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Selection mode |
| sel_src_pin_i | input | 1 | 1: manual select from pins, 0: from register |
| sel_reg_i | input | 2 | Manual select, register field |
| sel_pin_i | input | 2 | Manual select, external pins |
| rank_i | input | 8 | Four 2-bit priority ranks, field i at bits [2i+1:2i] |
| pair_i | input | 1 | Clock/frame-sync pairing mode |
| los_i | input | 4 | Loss-of-signal alarm per input |
| fos_i | input | 4 | Frequency-offset alarm per input |
| fos_en_i | input | 4 | Frequency-offset alarm enable per input |
| active_o | output | 2 | Encoded active candidate |
| hold_o | output | 1 | Hold state |
| switch_o | output | 1 | One-cycle strobe on any change of active_o or hold_o |

## Verification
The bench drives the non-revertive mode through a recovery of the best-ranked input and checks that the selection stays put. A design that reverted anyway, or one that failed to revert in revertive mode, would show a wrong active_o in the cycle after recovery. It also releases every alarm at once from hold in non-revertive mode. Here a design that kept a stale selection instead of re-ranking would report the old input. Further cases cover equal ranks (a wrong tie-break picks a higher index) and offset alarms with their enable cleared (an unmasked design drops into hold). Pairing mode is covered with a garbage rank in fields 2 and 3 and an alarm on a second pair member only. A design that read those fields or ignored the second member would choose the wrong pair.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int unsigned N_IN   = 4;
  localparam int unsigned RANK_W = 2;
  localparam int unsigned IDX_W  = $clog2(N_IN);

  typedef enum logic [1:0] {
    MODE_MAN   = 2'b00,
    MODE_NREV  = 2'b01,
    MODE_REV   = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  function automatic logic is_auto(input logic [1:0] m);
    return (m == MODE_NREV) || (m == MODE_REV);
  endfunction
endpackage

// File: rtl/refsel_qualify.sv
module refsel_qualify
  import refsel_pkg::*;
#(
  parameter int unsigned N = N_IN
) (
  input  logic [N-1:0] los_i,
  input  logic [N-1:0] fos_i,
  input  logic [N-1:0] fos_en_i,
  input  logic         pair_i,
  output logic [N-1:0] cand_bad_o
);
  localparam int unsigned HALF = N / 2;

  logic [N-1:0] in_bad;
  assign in_bad = los_i | (fos_i & fos_en_i);

  for (genvar k = 0; k < N; k++) begin : g_cand
    if (k < HALF) begin : g_lo
      // pair member k+HALF carries the frame sync of candidate k
      assign cand_bad_o[k] = pair_i ? (in_bad[k] | in_bad[k+HALF]) : in_bad[k];
    end else begin : g_hi
      assign cand_bad_o[k] = pair_i | in_bad[k];
    end
  end
endmodule

// File: rtl/refsel_rank.sv
module refsel_rank
  import refsel_pkg::*;
#(
  parameter int unsigned N  = N_IN,
  parameter int unsigned RW = RANK_W,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N*RW-1:0] rank_i,
  input  logic [N-1:0]    cand_bad_i,
  output logic [IW-1:0]   best_o,
  output logic            none_o
);
  logic [RW-1:0] best_r;
  logic          found;

  always_comb begin
    best_o = '0;
    best_r = '1;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lower index on a tie
      if (!cand_bad_i[i] && (!found || rank_i[i*RW +: RW] < best_r)) begin
        best_o = IW'(i);
        best_r = rank_i[i*RW +: RW];
        found  = 1'b1;
      end
    end
    none_o = !found;
  end
endmodule

// File: rtl/refsel_manual.sv
module refsel_manual
  import refsel_pkg::*;
#(
  parameter int unsigned N = N_IN,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          src_pin_i,
  input  logic [IW-1:0] sel_reg_i,
  input  logic [IW-1:0] sel_pin_i,
  input  logic [N-1:0]  cand_bad_i,
  output logic [IW-1:0] sel_o,
  output logic          sel_bad_o
);
  assign sel_o     = src_pin_i ? sel_pin_i : sel_reg_i;
  // unused pair codes are already marked bad by the qualifier
  assign sel_bad_o = cand_bad_i[sel_o];
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
  import refsel_pkg::*;
#(
  parameter int unsigned N = N_IN,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [N-1:0]  cand_bad_i,
  input  logic [IW-1:0] man_sel_i,
  input  logic          man_bad_i,
  input  logic [IW-1:0] best_i,
  input  logic          none_i,
  output logic [IW-1:0] active_o,
  output logic          hold_o,
  output logic          switch_o
);
  logic [IW-1:0] active_q, active_d;
  logic          hold_q, hold_d;
  logic          fresh_q, fresh_d;
  logic          switch_q;
  logic          cur_ok;
  logic          auto_m;

  assign auto_m = is_auto(mode_i);
  assign cur_ok = !fresh_q && !hold_q && !cand_bad_i[active_q];

  always_comb begin
    active_d = active_q;
    hold_d   = hold_q;
    fresh_d  = fresh_q;
    if (!auto_m) begin
      active_d = man_sel_i;
      hold_d   = man_bad_i;
      fresh_d  = 1'b1;
    end else if (none_i) begin
      hold_d   = 1'b1;
      fresh_d  = 1'b1;
    end else begin
      hold_d   = 1'b0;
      fresh_d  = 1'b0;
      if (!(mode_i == MODE_NREV && cur_ok)) active_d = best_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      hold_q   <= 1'b0;
      fresh_q  <= 1'b1;
      switch_q <= 1'b0;
    end else begin
      active_q <= active_d;
      hold_q   <= hold_d;
      fresh_q  <= fresh_d;
      switch_q <= (active_d != active_q) || (hold_d != hold_q);
    end
  end

  assign active_o = active_q;
  assign hold_o   = hold_q;
  assign switch_o = switch_q;

  AST_MAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_m && man_bad_i) |=> hold_q); // R4

  AST_AUTO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_m && (&cand_bad_i)) |=> (hold_q && $stable(active_q))); // R5

  AST_NREV_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NREV && cur_ok) |=> ($stable(active_q) && !hold_q)); // R8

  AST_REV_BEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_REV && !none_i) |=> (active_q == $past(best_i) && !hold_q)); // R7

  AST_STROBE_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_q |-> (active_q != $past(active_q) || hold_q != $past(hold_q))); // R11

  AST_STROBE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q != $past(active_q) || hold_q != $past(hold_q)) |-> switch_q); // R11
endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int unsigned N  = N_IN,
  parameter int unsigned RW = RANK_W,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          sel_src_pin_i,
  input  logic [IW-1:0] sel_reg_i,
  input  logic [IW-1:0] sel_pin_i,
  input  logic [N*RW-1:0] rank_i,
  input  logic          pair_i,
  input  logic [N-1:0]  los_i,
  input  logic [N-1:0]  fos_i,
  input  logic [N-1:0]  fos_en_i,
  output logic [IW-1:0] active_o,
  output logic          hold_o,
  output logic          switch_o
);
  logic [N-1:0]  cand_bad;
  logic [IW-1:0] best, man_sel;
  logic          none, man_bad;

  refsel_qualify #(.N(N)) u_qual (
    .los_i      (los_i),
    .fos_i      (fos_i),
    .fos_en_i   (fos_en_i),
    .pair_i     (pair_i),
    .cand_bad_o (cand_bad)
  );

  refsel_rank #(.N(N), .RW(RW)) u_rank (
    .rank_i     (rank_i),
    .cand_bad_i (cand_bad),
    .best_o     (best),
    .none_o     (none)
  );

  refsel_manual #(.N(N)) u_man (
    .src_pin_i  (sel_src_pin_i),
    .sel_reg_i  (sel_reg_i),
    .sel_pin_i  (sel_pin_i),
    .cand_bad_i (cand_bad),
    .sel_o      (man_sel),
    .sel_bad_o  (man_bad)
  );

  refsel_fsm #(.N(N)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .cand_bad_i (cand_bad),
    .man_sel_i  (man_sel),
    .man_bad_i  (man_bad),
    .best_i     (best),
    .none_i     (none),
    .active_o   (active_o),
    .hold_o     (hold_o),
    .switch_o   (switch_o)
  );

  AST_PAIR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_i && is_auto(mode_i) && !none) |=> (active_o < IW'(N/2))); // R10
endmodule

// File: tb/tb_refsel_top.sv
module tb_refsel_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [1:0] mode = 0, sel_reg = 0, sel_pin = 0;
  logic       src_pin = 0, pair = 0;
  logic [7:0] rank = 8'b11_10_01_00;
  logic [3:0] los = 0, fos = 0, fos_en = 0;
  logic [1:0] active;
  logic       hold, sw;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refsel_top dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sel_src_pin_i(src_pin),
    .sel_reg_i(sel_reg), .sel_pin_i(sel_pin), .rank_i(rank), .pair_i(pair),
    .los_i(los), .fos_i(fos), .fos_en_i(fos_en),
    .active_o(active), .hold_o(hold), .switch_o(sw)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic to_manual();
    mode = 2'b00; src_pin = 0; sel_reg = 0; pair = 0;
    los = 0; fos = 0; fos_en = 0; rank = 8'b11_10_01_00;
    step(); step();
  endtask

  task automatic t_reset();
    check("R11", "reset active", active, 0);
    check("R11", "reset hold", hold, 0);
    check("R11", "reset switch", sw, 0);
  endtask

  task automatic t_manual();
    to_manual();
    sel_reg = 2'd2; step();
    check("R2", "reg sel active", active, 2);
    check("R11", "strobe on change", sw, 1);
    step();
    check("R11", "strobe drops", sw, 0);
    src_pin = 1; sel_pin = 2'd3; step();
    check("R2", "pin sel active", active, 3);
    mode = 2'b11; src_pin = 0; sel_reg = 2'd1; step();
    check("R1", "reserved as manual", active, 1);
    check("R1", "reserved hold", hold, 0);
  endtask

  task automatic t_manual_alarm();
    to_manual();
    sel_reg = 2'd1; los = 4'b0010; step();
    check("R4", "los on selected", hold, 1);
    los = 0; fos = 4'b0010; fos_en = 4'b0000; step();
    check("R9", "masked fos", hold, 0);
    fos_en = 4'b0010; step();
    check("R9", "enabled fos", hold, 1);
    fos = 0; los = 4'b0001; step();
    check("R4", "alarm on other input", hold, 0);
  endtask

  task automatic t_auto_basic();
    to_manual();
    sel_reg = 2'd3; src_pin = 1; sel_pin = 2'd2; step();
    mode = 2'b01; step();
    check("R6", "auto entry best", active, 0);
    sel_reg = 2'd1; sel_pin = 2'd3; src_pin = 0; step();
    check("R3", "manual ignored", active, 0);
    check("R3", "no strobe", sw, 0);
    to_manual();
    rank = 8'b00_01_10_11; mode = 2'b10; step();
    check("R5", "reversed ranks", active, 3);
    rank = 8'b01_01_01_01; step();
    check("R5", "tie lower index", active, 0);
    los = 4'b0001; step();
    check("R5", "tie next", active, 1);
    fos = 4'b0010; fos_en = 4'b0000; step();
    check("R9", "masked fos keeps", active, 1);
    fos_en = 4'b0010; step();
    check("R9", "enabled fos moves", active, 2);
  endtask

  task automatic t_revert();
    to_manual();
    mode = 2'b10; step();
    los = 4'b0001; step();
    check("R7", "fail over", active, 1);
    los = 0; step();
    check("R7", "revert", active, 0);
    check("R11", "revert strobe", sw, 1);
  endtask

  task automatic t_nonrev();
    to_manual();
    mode = 2'b01; step();
    los = 4'b0001; step();
    check("R8", "fail over", active, 1);
    los = 0; step();
    check("R8", "stays", active, 1);
    check("R8", "no strobe", sw, 0);
    los = 4'b0010; step();
    check("R8", "moves on loss", active, 0);
  endtask

  task automatic t_hold();
    to_manual();
    mode = 2'b01; step();
    los = 4'b0001; step();
    los = 4'b1111; step();
    check("R5", "all bad hold", hold, 1);
    check("R5", "active kept", active, 1);
    check("R11", "hold strobe", sw, 1);
    step();
    check("R11", "hold strobe once", sw, 0);
    los = 0; step();
    check("R6", "leave hold best", active, 0);
    check("R6", "hold cleared", hold, 0);
  endtask

  task automatic t_pair();
    to_manual();
    pair = 1; rank = 8'b11_00_00_01; mode = 2'b10; step();
    check("R10", "pair rank", active, 1);
    los = 4'b1000; step();
    check("R10", "second member alarm", active, 0);
    los = 4'b1100; step();
    check("R10", "both pairs bad", hold, 1);
    los = 0; mode = 2'b00; sel_reg = 2'd2; step();
    check("R10", "unused code hold", hold, 1);
    sel_reg = 2'd1; step();
    check("R10", "pair manual", active, 1);
    check("R10", "pair manual hold", hold, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_manual();
        t_manual_alarm();
        t_auto_basic();
        t_revert();
        t_nonrev();
        t_hold();
        t_pair();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule